// File: doc/BRIEF.md
# Coprocessor Card Address Decoder and Bank Control

This block sits next to the 8-bit processor on an expansion card and turns its 16-bit address bus into chip selects. The selects cover a local SRAM, two ROM devices, one page of card-private I/O registers, and a window onto host memory. The SRAM is reachable both in low memory, for the zero page and the stack, and in an 8 KiB upper window. The first 512 bytes of that upper window alias the low region. The host window is live only while the card holds the host bus. Touching one page inside it raises an NMI request toward the host.

The I/O page holds a switch status register, a banking register and three strobe registers. A strobe register acts on any write, whatever the data. The strobes end the bus takeover, select ROM 2, and select ROM 1. The banking register supplies the upper address lines that extend the 8 KiB windows to 32 KiB of SRAM and 64 KiB per ROM. It also holds the native-mode capture enable.

Top module: `cop_addr_decode`

## Requirements
- R1: Address ranges decode as follows, with at most one select active at a time:
  - `sram_cs` for $0000-$01FF and $A000-$BFFF.
  - `io_cs` for $0200-$02FF.
  - `rom1_cs` or `rom2_cs` for $E000-$FFFF.
- R2: `host_cs` is high for $0300-$9FFF only while `bus_held` is 1. With `bus_held` at 0, and for $C000-$DFFF, no select is high and `rd_data` reads $FF.
- R3: `host_nmi` is high exactly when `host_cs` is high and the address lies in $0C00-$0CFF.
- R4: After reset, ROM 1 is selected. A write of any data to $0202 selects ROM 2 from the next cycle on, and a write of any data to $0203 selects ROM 1 again.
- R5: A write to $0201 raises `end_takeover` for exactly the one cycle after the write edge.
- R6: The banking register at $0204 resets to $00 and is written on the clock edge ending the write. It reads back with bits 7 and 5 forced to 0.
- R7: The banking register bits map to outputs as follows:
  - Bits 1:0 drive `rom_bank[1:0]` (ROM A14:A13) and bit 6 drives `rom_bank[2]` (ROM A15).
  - Bits 3:2 drive `sram_bank` (SRAM A14:A13).
  - Bit 4 drives `capture_en`.
- R8: `sram_bank` carries the bank bits only for $A200-$BFFF. For $0000-$01FF and its alias $A000-$A1FF it is 2'b00.
- R9: A read of $0200 returns `{dip_sw[6:0], dataread_in}`, with `dataread_in` live on bit 0. Offsets of page $02 other than $00 and $04 read $FF, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Processor address bus |
| wr_en | input | 1 | Write cycle qualifier |
| wr_data | input | 8 | Processor write data |
| bus_held | input | 1 | Card owns the host bus |
| dataread_in | input | 1 | Live data-read line |
| dip_sw | input | 7 | Configuration switches 7..1 |
| rd_data | output | 8 | Register read data, $FF when unmapped |
| sram_cs | output | 1 | SRAM select |
| io_cs | output | 1 | Register page select |
| host_cs | output | 1 | Host memory window strobe |
| rom1_cs | output | 1 | ROM 1 select |
| rom2_cs | output | 1 | ROM 2 select |
| sram_bank | output | 2 | SRAM A14:A13 |
| rom_bank | output | 3 | ROM A15:A13 |
| capture_en | output | 1 | Native-mode capture enable |
| host_nmi | output | 1 | NMI request to host |
| end_takeover | output | 1 | One-cycle end-of-DMA pulse |

## Verification
The bench builds the block with its defaults: register page $02 and NMI page $0C. These values put the range edges $01FF/$0200, $02FF/$0300, $9FFF/$A000, $A1FF/$A200, $DFFF/$E000 and both edges of the NMI page within reach of a short vector table. That table is swept with `bus_held` both high and low. Directed sequences then cover the ROM strobe order, the length of the takeover pulse, the masked banking readback, and writes to dead offsets.

// File: rtl/cop_addr_decode.sv
module cop_addr_decode #(
  parameter logic [7:0] IO_PAGE  = 8'h02,
  parameter logic [7:0] NMI_PAGE = 8'h0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        bus_held,
  input  logic        dataread_in,
  input  logic [6:0]  dip_sw,
  output logic [7:0]  rd_data,
  output logic        sram_cs,
  output logic        io_cs,
  output logic        host_cs,
  output logic        rom1_cs,
  output logic        rom2_cs,
  output logic [1:0]  sram_bank,
  output logic [2:0]  rom_bank,
  output logic        capture_en,
  output logic        host_nmi,
  output logic        end_takeover
);

  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_END  = 8'h01;
  localparam logic [7:0] OFS_ROM2 = 8'h02;
  localparam logic [7:0] OFS_ROM1 = 8'h03;
  localparam logic [7:0] OFS_BANK = 8'h04;
  localparam logic [7:0] BANK_MASK = 8'h5F;

  logic [7:0] bank_q;
  logic       rom2_q;
  logic       end_q;

  wire low_sram = addr[15:9] == 7'd0;
  wire mirror   = addr[15:9] == 7'b1010000;
  wire hi_sram  = addr[15:13] == 3'b101;
  wire in_io    = addr[15:8] == IO_PAGE;
  wire in_host  = (addr >= 16'h0300) && (addr <= 16'h9FFF) && !in_io;
  wire in_rom   = addr[15:13] == 3'b111;
  wire [7:0] ofs = addr[7:0];
  wire io_wr    = wr_en && in_io;

  assign sram_cs  = low_sram || hi_sram;
  assign io_cs    = in_io;
  assign host_cs  = in_host && bus_held;
  assign rom1_cs  = in_rom && !rom2_q;
  assign rom2_cs  = in_rom && rom2_q;
  assign host_nmi = host_cs && (addr[15:8] == NMI_PAGE);

  assign sram_bank  = (hi_sram && !mirror) ? bank_q[3:2] : 2'b00;
  assign rom_bank   = {bank_q[6], bank_q[1:0]};
  assign capture_en = bank_q[4];
  assign end_takeover = end_q;

  always_comb begin
    rd_data = 8'hFF;
    if (in_io && ofs == OFS_STAT) rd_data = {dip_sw, dataread_in};
    else if (in_io && ofs == OFS_BANK) rd_data = bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 8'h00;
      rom2_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      end_q <= io_wr && ofs == OFS_END;
      if (io_wr && ofs == OFS_BANK) bank_q <= wr_data & BANK_MASK;
      if (io_wr && ofs == OFS_ROM2) rom2_q <= 1'b1;
      else if (io_wr && ofs == OFS_ROM1) rom2_q <= 1'b0;
    end
  end

endmodule

module cop_addr_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        wr_en,
  input logic        bus_held,
  input logic        sram_cs,
  input logic        io_cs,
  input logic        host_cs,
  input logic        rom1_cs,
  input logic        rom2_cs,
  input logic        host_nmi,
  input logic        end_takeover
);
  // R1
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_cs, io_cs, host_cs, rom1_cs, rom2_cs}));
  // R2
  no_host_unheld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_held |-> !host_cs);
  // R3
  nmi_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_nmi |-> host_cs);
  // R5
  end_pulse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_takeover |=> (!end_takeover || $past(wr_en && addr == 16'h0201)));
  // R4
  rom2_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'h0202) |=> (addr[15:13] == 3'b111) -> rom2_cs);
endmodule

bind cop_addr_decode cop_addr_decode_chk i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .bus_held(bus_held),
  .sram_cs(sram_cs), .io_cs(io_cs), .host_cs(host_cs), .rom1_cs(rom1_cs),
  .rom2_cs(rom2_cs), .host_nmi(host_nmi), .end_takeover(end_takeover)
);

// File: tb/test_cop_addr_decode.sv
module test_cop_addr_decode;
  logic clk = 0, rst_n = 0, wr_en = 0, bus_held = 0, dataread_in = 0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wr_data = 8'h00;
  logic [6:0] dip_sw = 7'h00;
  logic [7:0] rd_data;
  logic sram_cs, io_cs, host_cs, rom1_cs, rom2_cs, capture_en, host_nmi, end_takeover;
  logic [1:0] sram_bank;
  logic [2:0] rom_bank;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  cop_addr_decode #(.IO_PAGE(8'h02), .NMI_PAGE(8'h0C)) i_cop_addr_decode (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .bus_held(bus_held), .dataread_in(dataread_in), .dip_sw(dip_sw),
    .rd_data(rd_data), .sram_cs(sram_cs), .io_cs(io_cs), .host_cs(host_cs),
    .rom1_cs(rom1_cs), .rom2_cs(rom2_cs), .sram_bank(sram_bank),
    .rom_bank(rom_bank), .capture_en(capture_en), .host_nmi(host_nmi),
    .end_takeover(end_takeover));

  // {addr, bus_held, cs{sram,io,host,rom1,rom2}, nmi}
  localparam int NV = 20;
  localparam logic [22:0] VEC [NV] = '{
    {16'h0000, 1'b0, 5'b10000, 1'b0}, {16'h01FF, 1'b0, 5'b10000, 1'b0},
    {16'h0200, 1'b0, 5'b01000, 1'b0}, {16'h02FF, 1'b1, 5'b01000, 1'b0},
    {16'h0300, 1'b0, 5'b00000, 1'b0}, {16'h0300, 1'b1, 5'b00100, 1'b0},
    {16'h0BFF, 1'b1, 5'b00100, 1'b0}, {16'h0C00, 1'b1, 5'b00100, 1'b1},
    {16'h0CFF, 1'b1, 5'b00100, 1'b1}, {16'h0C80, 1'b0, 5'b00000, 1'b0},
    {16'h0D00, 1'b1, 5'b00100, 1'b0}, {16'h9FFF, 1'b1, 5'b00100, 1'b0},
    {16'h9FFF, 1'b0, 5'b00000, 1'b0}, {16'hA000, 1'b1, 5'b10000, 1'b0},
    {16'hBFFF, 1'b0, 5'b10000, 1'b0}, {16'hC000, 1'b1, 5'b00000, 1'b0},
    {16'hDFFF, 1'b1, 5'b00000, 1'b0}, {16'hE000, 1'b0, 5'b00010, 1'b0},
    {16'hFFFF, 1'b1, 5'b00010, 1'b0}, {16'h5000, 1'b1, 5'b00100, 1'b0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 16'h1000;
  endtask

  task automatic at(input logic [15:0] a);
    addr = a; #1;
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // reset state, R6 R4
    at(16'h0204); chk("R6", rd_data, 8'h00);
    at(16'hE000); chk("R4", {rom1_cs, rom2_cs}, 2'b10);
    chk("R5", end_takeover, 0);
    rst_n = 1;
    @(negedge clk);
    // table: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      bus_held = VEC[i][6]; at(VEC[i][22:7]);
      chk("R1", {sram_cs, io_cs, host_cs, rom1_cs, rom2_cs}, VEC[i][5:1]);
      chk("R3", host_nmi, VEC[i][0]);
      if (VEC[i][5:1] == 5'b0) chk("R2", rd_data, 8'hFF);
    end
    // R4 strobes, data ignored
    wr(16'h0202, 8'h00); at(16'hF000); chk("R4", {rom1_cs, rom2_cs}, 2'b01);
    wr(16'h0202, 8'hA5); at(16'hF000); chk("R4", {rom1_cs, rom2_cs}, 2'b01);
    wr(16'h0203, 8'h3C); at(16'hE123); chk("R4", {rom1_cs, rom2_cs}, 2'b10);
    // R5 pulse
    @(negedge clk); addr = 16'h0201; wr_data = 8'h77; wr_en = 1;
    #1 chk("R5", end_takeover, 0);
    @(negedge clk); wr_en = 0; addr = 16'h1000;
    chk("R5", end_takeover, 1);
    @(negedge clk); chk("R5", end_takeover, 0);
    // R6 R7 banking
    wr(16'h0204, 8'hFF); at(16'h0204); chk("R6", rd_data, 8'h5F);
    chk("R7", {rom_bank, capture_en}, {3'b111, 1'b1});
    at(16'hA200); chk("R7", sram_bank, 2'b11);
    wr(16'h0204, 8'h46); at(16'hB000);
    chk("R7", {rom_bank, sram_bank, capture_en}, {3'b110, 2'b01, 1'b0});
    // R8 aliasing
    at(16'hA1FF); chk("R8", sram_bank, 2'b00);
    at(16'h0100); chk("R8", sram_bank, 2'b00);
    // R9 status and dead offsets
    dip_sw = 7'h55; dataread_in = 1; at(16'h0200); chk("R9", rd_data, 8'hAB);
    dataread_in = 0; #1 chk("R9", rd_data, 8'hAA);
    at(16'h0205); chk("R9", rd_data, 8'hFF);
    wr(16'h0280, 8'h13); at(16'h0204); chk("R9", rd_data, 8'h46);
    at(16'hE000); chk("R9", {rom1_cs, rom2_cs}, 2'b10);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule